// File: doc/BRIEF.md
# Reference Clock Source Selector

This block watches two external 10 MHz reference inputs for activity: one arriving from a timing module and one arriving from a rear-panel connector. It decides whether the system clock generator should lock to one of them or fall back to the internal oscillator. Nothing is written by software. The choice follows a fixed priority that depends only on which inputs are judged present.

Each reference is brought into the local clock domain and its rising edges are counted over a gate window. The local clock is free-running, and a shared timer sets the window length. An input is judged good in a window when its count lies inside a band around the nominal count. That band is wide enough to cover a ±100 ppm reference and the error of the local oscillator. Presence uses hysteresis: two good windows in a row set it, and two bad windows in a row clear it.

The outputs are a 2-bit source code, one presence flag per input and a one-cycle change event. They feed a clock multiplexer or a PLL controller.

Top module: `refsel_top`

## Requirements
- R1: During and right after reset, `sel_code` is 00, both presence flags are 0 and `sel_change` is 0.
- R2: With neither presence flag set, `sel_code` settles to 00 (internal oscillator).
- R3: With only `rear_present` set, `sel_code` settles to 01 (rear connector).
- R4: With `mod_present` set, `sel_code` settles to 10 (timing module), whatever the state of `rear_present`.
- R5: A window counts as good when its rising-edge count lies in [NOM_EDGES-EDGE_TOL, NOM_EDGES+EDGE_TOL]. The defaults are 10000 local cycles and 1000±1 edges, which accept a ±100 ppm reference. A missing, too slow or too fast input never becomes present.
- R6: A presence flag sets only after two consecutive good windows and clears only after two consecutive bad windows. A single bad window leaves a set flag set.
- R7: `sel_code` changes only in the cycle after a gate-window boundary, and it never takes the value 11.
- R8: `sel_change` is high for exactly the cycles in which `sel_code` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_module | input | 1 | Reference from the timing module (asynchronous) |
| ref_rear | input | 1 | Reference from the rear connector (asynchronous) |
| sel_code | output | 2 | Chosen source: 00 internal, 01 rear, 10 timing module |
| mod_present | output | 1 | Timing-module reference judged present |
| rear_present | output | 1 | Rear-connector reference judged present |
| sel_change | output | 1 | One-cycle pulse when `sel_code` changes |

## Verification
A wrong edge count or a wrong comparison band shows up as a presence flag that sets for a fast or slow input, or that stays clear for a good one. This is visible within about two to three gate windows after the input changes. A broken hysteresis state shows up at the ports in one of two ways. A flag may set after only one window, which is caught by checking the flag one window after an input starts. Or a flag may drop on a short glitch, which is caught by watching the flag continuously through a gap of a few edges. Errors in priority or encoding show up directly on `sel_code` one cycle after the next window boundary. A mismatch between the event output and the code is caught by comparing the two every cycle.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'b00,
        SRC_REAR     = 2'b01,
        SRC_MODULE   = 2'b10
    } src_e;

    // Per-channel qualification state
    typedef struct packed {
        logic present;    // qualified presence flag
        logic last_good;  // verdict of the previous window
    } chan_st_t;

    // Fixed priority: timing module over rear connector over internal
    function automatic src_e pick_source(input logic mod_ok, input logic rear_ok);
        if (mod_ok)       return SRC_MODULE;
        else if (rear_ok) return SRC_REAR;
        else              return SRC_INTERNAL;
    endfunction

    function automatic logic in_band(input int unsigned n,
                                     input int unsigned lo,
                                     input int unsigned hi);
        return (n >= lo) && (n <= hi);
    endfunction

endpackage

// File: rtl/refsel_sync_edge.sv
module refsel_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    // chain[STAGES-1] is the last synchronizer stage, chain[STAGES] its delayed copy
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/refsel_gate_timer.sv
module refsel_gate_timer #(
    parameter int GATE_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int TW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst)               tcnt <= '0;
        else if (tcnt == LAST) tcnt <= '0;
        else                   tcnt <= tcnt + 1'b1;
    end

    assign win_end = (tcnt == LAST);
endmodule

// File: rtl/refsel_edge_window.sv
module refsel_edge_window
    import refsel_pkg::*;
#(
    parameter int NOM_EDGES = 1000,
    parameter int EDGE_TOL  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic win_end,
    output logic present
);
    localparam int LO    = NOM_EDGES - EDGE_TOL;
    localparam int HI    = NOM_EDGES + EDGE_TOL;
    localparam int CNT_W = $clog2(HI + 2);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] ecnt;
    logic [CNT_W-1:0] total;
    logic             good;
    chan_st_t         st;

    // Count including an edge seen in the closing cycle, saturating
    always_comb begin
        if (rise && ecnt != SAT) total = ecnt + 1'b1;
        else                     total = ecnt;
        good = in_band(int'(total), LO, HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt <= '0;
        end else if (win_end) begin
            ecnt <= '0;
        end else begin
            ecnt <= total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (win_end) begin
            st.last_good <= good;
            if (good && st.last_good)        st.present <= 1'b1;
            else if (!good && !st.last_good) st.present <= 1'b0;
        end
    end

    assign present = st.present;
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
#(
    parameter int GATE_CYCLES = 10000,
    parameter int NOM_EDGES   = 1000,
    parameter int EDGE_TOL    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_module,
    input  logic       ref_rear,
    output logic [1:0] sel_code,
    output logic       mod_present,
    output logic       rear_present,
    output logic       sel_change
);
    localparam int NCH = 2;  // index 0: timing module, index 1: rear connector

    logic [NCH-1:0] ref_in;
    logic [NCH-1:0] rise;
    logic [NCH-1:0] pres;
    logic           win_tick;
    logic           upd_q;
    src_e           sel_q;
    src_e           sel_next;

    assign ref_in = {ref_rear, ref_module};

    refsel_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        refsel_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (ref_in[i]),
            .rise     (rise[i])
        );
        refsel_edge_window #(.NOM_EDGES(NOM_EDGES), .EDGE_TOL(EDGE_TOL)) u_win (
            .clk     (clk),
            .rst     (rst),
            .rise    (rise[i]),
            .win_end (win_tick),
            .present (pres[i])
        );
    end

    // Presence settles at the window edge; the choice follows one cycle later
    always_ff @(posedge clk) begin
        if (rst) upd_q <= 1'b0;
        else     upd_q <= win_tick;
    end

    assign sel_next = pick_source(pres[0], pres[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= SRC_INTERNAL;
            sel_change <= 1'b0;
        end else if (upd_q) begin
            sel_q      <= sel_next;
            sel_change <= (sel_next != sel_q);
        end else begin
            sel_change <= 1'b0;
        end
    end

    assign sel_code     = sel_q;
    assign mod_present  = pres[0];
    assign rear_present = pres[1];
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel_code,
    input logic       sel_change,
    input logic       mod_present,
    input logic       rear_present,
    input logic       win_tick,
    input logic       upd
);
    // R7: the reserved code is never produced
    a_r7_no_reserved_code: assert property (@(posedge clk) disable iff (rst)
        sel_code != 2'b11);

    // R7: the code moves only right after a window boundary
    a_r7_change_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_code) |-> $past(upd));

    // R6: presence flags move only on a window boundary
    a_r6_mod_flag_on_window: assert property (@(posedge clk) disable iff (rst)
        !$stable(mod_present) |-> $past(win_tick));
    a_r6_rear_flag_on_window: assert property (@(posedge clk) disable iff (rst)
        !$stable(rear_present) |-> $past(win_tick));

    // R4: module presence wins
    a_r4_module_priority: assert property (@(posedge clk) disable iff (rst)
        upd && mod_present |=> sel_code == 2'b10);

    // R3: rear alone
    a_r3_rear_only: assert property (@(posedge clk) disable iff (rst)
        upd && !mod_present && rear_present |=> sel_code == 2'b01);

    // R2: nothing present
    a_r2_internal_fallback: assert property (@(posedge clk) disable iff (rst)
        upd && !mod_present && !rear_present |=> sel_code == 2'b00);

    // R8: event pulse matches a code change
    a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_code) |-> sel_change);
    a_r8_pulse_only_on_change: assert property (@(posedge clk) disable iff (rst)
        sel_change |-> !$stable(sel_code));
endmodule

bind refsel_top refsel_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_code     (sel_code),
    .sel_change   (sel_change),
    .mod_present  (mod_present),
    .rear_present (rear_present),
    .win_tick     (win_tick),
    .upd          (upd_q)
);

// File: tb/sim_refsel_top.sv
`timescale 1ns/1ps
module sim_refsel_top;
    localparam int GATE = 64;
    localparam int NOM  = 8;
    localparam int TOL  = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_module = 1'b0;
    logic       ref_rear = 1'b0;
    logic [1:0] sel_code;
    logic       mod_present, rear_present, sel_change;

    int checks = 0;
    int failures = 0;
    int per_mod = 0;
    int per_rear = 0;
    int ph_mod = 0;
    int ph_rear = 0;
    int pulses = 0;
    logic [1:0] prev_sel = 2'b00;
    logic watch_rear = 1'b0;
    logic rear_dropped = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    refsel_top #(.GATE_CYCLES(GATE), .NOM_EDGES(NOM), .EDGE_TOL(TOL)) u0 (
        .clk(clk), .rst(rst), .ref_module(ref_module), .ref_rear(ref_rear),
        .sel_code(sel_code), .mod_present(mod_present),
        .rear_present(rear_present), .sel_change(sel_change)
    );

    // Reference generators: period in local cycles, 0 means held low
    always @(negedge clk) begin
        if (per_mod == 0) begin ph_mod = 0; ref_module <= 1'b0; end
        else begin
            ph_mod = (ph_mod + 1) % per_mod;
            ref_module <= (ph_mod < per_mod / 2);
        end
        if (per_rear == 0) begin ph_rear = 0; ref_rear <= 1'b0; end
        else begin
            ph_rear = (ph_rear + 1) % per_rear;
            ref_rear <= (ph_rear < per_rear / 2);
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R8 monitor: pulse exactly when the code differs from the previous cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (sel_change) pulses++;
            if (sel_change || (sel_code != prev_sel))
                chk("R8", int'(sel_change), int'(sel_code != prev_sel), "pulse vs code change");
            if (watch_rear && !rear_present) rear_dropped = 1'b1;
        end
        prev_sel = sel_code;
    end

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Apply a new pair of periods, let it settle, check outputs
    task automatic step(input int pm, input int pr, input int exp_mod, input int exp_rear,
                        input int exp_sel, input string req);
        int old_sel;
        old_sel = int'(sel_code);
        pulses = 0;
        per_mod = pm;
        per_rear = pr;
        wait_cycles(5 * GATE);
        #1;
        chk(req, int'(mod_present), exp_mod, "module presence");
        chk(req, int'(rear_present), exp_rear, "rear presence");
        chk(req, int'(sel_code), exp_sel, "source code");
        chk("R8", pulses, (old_sel != exp_sel) ? 1 : 0, "event count");
    endtask

    initial begin
        wait_cycles(4);
        #1;
        chk("R1", int'(sel_code), 0, "code in reset");
        chk("R1", int'(mod_present) + int'(rear_present), 0, "flags in reset");
        chk("R1", int'(sel_change), 0, "event in reset");
        @(negedge clk);
        rst = 1'b0;
        wait_cycles(3 * GATE);
        #1;
        chk("R2", int'(sel_code), 0, "idle internal");

        step(0, 8, 0, 1, 1, "R3");      // rear alone, nominal
        step(8, 8, 1, 1, 2, "R4");      // module joins
        step(8, 0, 1, 0, 2, "R4");      // rear lost, module kept
        step(8, 6, 1, 0, 2, "R5");      // rear too fast
        step(12, 6, 0, 0, 0, "R5");     // module too slow: internal
        step(12, 9, 0, 1, 1, "R5");     // rear at edge of band accepted
        step(4, 9, 0, 1, 1, "R5");      // module too fast ignored
        step(8, 9, 1, 1, 2, "R4");
        step(0, 8, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 0, "R2");

        // R6: set needs two good windows; one window after start it is still clear
        per_rear = 8;
        wait_cycles(GATE);
        #1;
        chk("R6", int'(rear_present), 0, "flag after one window");
        wait_cycles(4 * GATE);
        #1;
        chk("R6", int'(rear_present), 1, "flag after settling");

        // R6: a short gap (at most one bad window) must not clear it
        watch_rear = 1'b1;
        per_rear = 0;
        wait_cycles(20);
        per_rear = 8;
        wait_cycles(4 * GATE);
        watch_rear = 1'b0;
        chk("R6", int'(rear_dropped), 0, "flag kept over short gap");

        // R6: clearing also waits for two bad windows
        per_rear = 0;
        wait_cycles(GATE);
        #1;
        chk("R6", int'(rear_present), 1, "flag one window after loss");
        wait_cycles(4 * GATE);
        #1;
        chk("R6", int'(rear_present), 0, "flag after sustained loss");
        chk("R7", int'(sel_code), 0, "code back to internal");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule